// File: doc/BRIEF.md
# UART Status and Interrupt Flag Register

This block keeps the flag state of a UART: three sticky receive-error flags (parity, overrun, framing), a flag that says a received byte is waiting, and a flag that says the transmit buffer can take a byte. It also holds three writable control bits and turns the flags and two enable bits into one receive and one transmit interrupt request. The receive and transmit engines report events to it through one-cycle strobes. A small register bus reads the 8-bit status byte, strobes reads of the status and data registers, and writes the byte.

The error flags are sticky. No read clears them, whether of the status or of the data register. Software clears all three at once by writing 0 to bit 10, which is shared with the bit-order select. A write of 1 there leaves the errors unchanged. The data-full flag works differently: it clears by itself when the data register is read. Whenever any error flag is set, the received byte must be treated as invalid, and a valid output says so. When a setting event and a clearing action arrive in the same cycle, the setting event wins.

Two small state machines track the data-full and transmit-empty flags. The receive machine has the states `RX_IDLE` (no byte) and `RX_HELD` (byte waiting). Its transition `RX_IDLE -> RX_HELD` happens on a load. Its transition `RX_HELD -> RX_IDLE` happens on a data read with no load in the same cycle. The transmit machine has the states `TX_FREE` (buffer empty) and `TX_BUSY` (buffer holds a byte). Its transition `TX_FREE -> TX_BUSY` happens on a buffer write with no take in the same cycle. Its transition `TX_BUSY -> TX_FREE` happens when the transmitter takes the byte. Each error flag is a two-state bank entry, clear or set. Every flag update takes effect on the clock edge after its strobe.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset the status byte `rd_stat` (bit 7..0 = register bits 15..8) reads 8'b0000_1000: only transmit-empty (bit 3) is 1.
- R2: The strobes `ev_par`, `ev_ovr` and `ev_frm` set `rd_stat[7]`, `rd_stat[6]` and `rd_stat[5]` respectively on the next clock. These flags stay set across status reads, data reads and any other traffic until they are cleared.
- R3: A write with `wr_data[2]`=0 clears all three error flags on the next clock. A write with `wr_data[2]`=1 leaves the error flags unchanged.
- R4: An error strobe in the same cycle as a clearing write leaves that flag set.
- R5: `ev_rx_load` sets data-full `rd_stat[4]` on the next clock, and `data_rd` clears it. When a load and a data read arrive in the same cycle, the flag ends up 1.
- R6: `ev_tx_load` clears transmit-empty `rd_stat[3]`, and `ev_tx_take` sets it. When both arrive in the same cycle, the flag ends up 1.
- R7: A write stores `wr_data[2:0]` into `rd_stat[2:0]`: bit 2 is the bit-order select, bit 1 the receive interrupt enable, bit 0 the transmit interrupt enable. Bit 2 reads back the stored value. Write data in bits 7..3 has no effect.
- R8: `rx_data_valid` is 0 while any error flag is 1, and 1 otherwise.
- R9: `irq_rx` is 1 exactly when `rd_stat[1]` is 1 and at least one of `rd_stat[7:4]` is 1.
- R10: `irq_tx` is 1 exactly when `rd_stat[0]` and `rd_stat[3]` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_par | input | 1 | Parity error strobe |
| ev_ovr | input | 1 | Overrun error strobe |
| ev_frm | input | 1 | Framing error strobe |
| ev_rx_load | input | 1 | Received byte loaded into the data register |
| ev_tx_load | input | 1 | Transmit buffer written |
| ev_tx_take | input | 1 | Transmitter took the buffered byte |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Receive data register read strobe |
| wr_en | input | 1 | Write strobe for the status byte |
| wr_data | input | 8 | Write data, bit 7..0 = register bits 15..8 |
| rd_stat | output | 8 | Status byte, bit 7..0 = register bits 15..8 |
| rx_data_valid | output | 1 | Received byte is usable |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The conflicts that matter are set-against-clear pairs in one cycle. An error strobe can land on a clearing write, a byte load can land on a data read, and a buffer write can land on a byte take. Directed sequences force each pair. Long random stretches with dense strobes and writes produce many more. A behavioural model in the bench predicts every output, and the bench compares the design against it after every clock. In each pair the flag must end up set.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_ERR = 3;
    localparam int CTL_W   = 3;
    // positions inside the status byte (bit 7..0 = register bits 15..8)
    localparam int POS_PAR  = 7;
    localparam int POS_OVR  = 6;
    localparam int POS_FRM  = 5;
    localparam int POS_FULL = 4;
    localparam int POS_TXE  = 3;
    localparam int POS_CLR  = 2;
    localparam int POS_RIE  = 1;
    localparam int POS_TIE  = 0;

    typedef enum logic {RX_IDLE = 1'b0, RX_HELD = 1'b1} rx_state_t;
    typedef enum logic {TX_BUSY = 1'b0, TX_FREE = 1'b1} tx_state_t;
    typedef enum logic {ERR_CLEAR = 1'b0, ERR_SET = 1'b1} err_state_t;
endpackage

// File: rtl/uart_err_bank.sv
module uart_err_bank
    import uart_stat_pkg::*;
#(
    parameter int N = NUM_ERR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        err_state_t st_q, st_d;

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                ERR_CLEAR: if (ev[i]) st_d = ERR_SET;
                ERR_SET:   if (clr && !ev[i]) st_d = ERR_CLEAR;
                default:   st_d = ERR_CLEAR;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= ERR_CLEAR;
            else        st_q <= st_d;
        end

        assign flag[i] = (st_q == ERR_SET);

        p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flag[i]);
        p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr) |=> flag[i]);
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !ev[i]) |=> !flag[i]);
        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && ev[i]) |=> flag[i]);
    end
endmodule

// File: rtl/uart_rx_full_fsm.sv
module uart_rx_full_fsm
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rd,
    output logic full
);
    rx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE: if (load) st_d = RX_HELD;
            RX_HELD: if (rd && !load) st_d = RX_IDLE;
            default: st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    assign full = (st_q == RX_HELD);

    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> !full);
endmodule

// File: rtl/uart_tx_empty_fsm.sv
module uart_tx_empty_fsm
    import uart_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_buf,
    input  logic take,
    output logic empty
);
    tx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_FREE: if (wr_buf && !take) st_d = TX_BUSY;
            TX_BUSY: if (take) st_d = TX_FREE;
            default: st_d = TX_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_FREE;
        else        st_q <= st_d;
    end

    assign empty = (st_q == TX_FREE);

    p_take_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> empty);
    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_buf && !take) |=> !empty);
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
    import uart_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_par,
    input  logic             ev_ovr,
    input  logic             ev_frm,
    input  logic             ev_rx_load,
    input  logic             ev_tx_load,
    input  logic             ev_tx_take,
    input  logic             stat_rd,
    input  logic             data_rd,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_stat,
    output logic             rx_data_valid,
    output logic             irq_rx,
    output logic             irq_tx
);
    logic [NUM_ERR-1:0] err_ev, err;
    logic [CTL_W-1:0]   ctl_q;
    logic               clr_req, full, empty;

    assign err_ev  = {ev_par, ev_ovr, ev_frm};
    assign clr_req = wr_en && !wr_data[POS_CLR];

    uart_err_bank #(.N(NUM_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .ev(err_ev), .clr(clr_req), .flag(err)
    );

    uart_rx_full_fsm u_rx (
        .clk(clk), .rst_n(rst_n), .load(ev_rx_load), .rd(data_rd), .full(full)
    );

    uart_tx_empty_fsm u_tx (
        .clk(clk), .rst_n(rst_n), .wr_buf(ev_tx_load), .take(ev_tx_take), .empty(empty)
    );

    // writable control bits: bit-order select / clear request, rx enable, tx enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data[CTL_W-1:0];
    end

    always_comb begin
        rd_stat                = '0;
        rd_stat[POS_PAR:POS_FRM] = err;
        rd_stat[POS_FULL]      = full;
        rd_stat[POS_TXE]       = empty;
        rd_stat[CTL_W-1:0]     = ctl_q;
        rx_data_valid          = ~|err;
        irq_rx                 = ctl_q[POS_RIE] && (full || (|err));
        irq_tx                 = ctl_q[POS_TIE] && empty;
    end

    p_stat_read_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && rd_stat[POS_PAR] && !clr_req) |=> rd_stat[POS_PAR]);
    p_ctl_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_stat[CTL_W-1:0] == $past(wr_data[CTL_W-1:0])));
    p_ro_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|wr_data[REG_W-1:CTL_W]) && wr_data[POS_CLR] && !(|err_ev)
         && !ev_rx_load && !data_rd && !ev_tx_load && !ev_tx_take)
        |=> $stable(rd_stat[REG_W-1:CTL_W]));
    p_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovr |=> !rx_data_valid);
    p_irq_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_load && ctl_q[POS_RIE] && !wr_en) |=> irq_rx);
    p_irq_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_take && ctl_q[POS_TIE] && !wr_en) |=> irq_tx);
endmodule

// File: tb/sim_uart_stat_reg.sv
module sim_uart_stat_reg;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_par = 0, ev_ovr = 0, ev_frm = 0, ev_rx_load = 0;
    logic ev_tx_load = 0, ev_tx_take = 0, stat_rd = 0, data_rd = 0, wr_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_stat;
    logic rx_data_valid, irq_rx, irq_tx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit m_par, m_ovr, m_frm, m_full, m_empty, m_bos, m_rie, m_tie;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_stat_reg u0 (
        .clk(clk), .rst_n(rst_n), .ev_par(ev_par), .ev_ovr(ev_ovr), .ev_frm(ev_frm),
        .ev_rx_load(ev_rx_load), .ev_tx_load(ev_tx_load), .ev_tx_take(ev_tx_take),
        .stat_rd(stat_rd), .data_rd(data_rd), .wr_en(wr_en), .wr_data(wr_data),
        .rd_stat(rd_stat), .rx_data_valid(rx_data_valid), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] model_byte();
        return {m_par, m_ovr, m_frm, m_full, m_empty, m_bos, m_rie, m_tie};
    endfunction

    task automatic compare_all(input string etag);
        chk(etag,  int'(rd_stat[7:5]), int'({m_par, m_ovr, m_frm}));
        chk("R5",  int'(rd_stat[4]), int'(m_full));
        chk("R6",  int'(rd_stat[3]), int'(m_empty));
        chk("R7",  int'(rd_stat[2:0]), int'({m_bos, m_rie, m_tie}));
        chk("R8",  int'(rx_data_valid), int'(!(m_par || m_ovr || m_frm)));
        chk("R9",  int'(irq_rx), int'(m_rie && (m_full || m_par || m_ovr || m_frm)));
        chk("R10", int'(irq_tx), int'(m_tie && m_empty));
    endtask

    task automatic idle_inputs();
        {ev_par, ev_ovr, ev_frm, ev_rx_load, ev_tx_load, ev_tx_take} = '0;
        {stat_rd, data_rd, wr_en} = '0;
        wr_data = '0;
    endtask

    // inputs already driven; advance one clock, update model, compare
    task automatic tick(input string etag);
        bit clr;
        clr = wr_en && !wr_data[2];
        @(posedge clk);
        m_par = (m_par && !clr) || ev_par;
        m_ovr = (m_ovr && !clr) || ev_ovr;
        m_frm = (m_frm && !clr) || ev_frm;
        if (ev_rx_load) m_full = 1;
        else if (data_rd) m_full = 0;
        if (ev_tx_take) m_empty = 1;
        else if (ev_tx_load) m_empty = 0;
        if (wr_en) {m_bos, m_rie, m_tie} = wr_data[2:0];
        @(negedge clk);
        compare_all(etag);
        idle_inputs();
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        idle_inputs();
        m_par = 0; m_ovr = 0; m_frm = 0; m_full = 0; m_empty = 1;
        m_bos = 0; m_rie = 0; m_tie = 0;
        repeat (3) @(negedge clk);
        chk("R1", int'(rd_stat), 8'h08);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(rd_stat), 8'h08);

        // R7: enable both interrupts, junk in read-only bits
        wr_en = 1; wr_data = 8'hFF; tick("R2");
        chk("R7", int'(rd_stat), 8'h0F);
        // R10: buffer write then take
        ev_tx_load = 1; tick("R2");
        chk("R10", int'(irq_tx), 0);
        ev_tx_take = 1; tick("R2");
        chk("R10", int'(irq_tx), 1);
        // R6: write and take in the same cycle
        ev_tx_load = 1; ev_tx_take = 1; tick("R2");
        chk("R6", int'(rd_stat[3]), 1);

        // R5: load, same-cycle load+read, then plain read
        ev_rx_load = 1; tick("R2");
        chk("R9", int'(irq_rx), 1);
        ev_rx_load = 1; data_rd = 1; tick("R2");
        chk("R5", int'(rd_stat[4]), 1);
        data_rd = 1; tick("R2");
        chk("R5", int'(rd_stat[4]), 0);

        // R2: errors sticky across reads
        ev_par = 1; tick("R2");
        chk("R8", int'(rx_data_valid), 0);
        stat_rd = 1; data_rd = 1; tick("R2");
        chk("R2", int'(rd_stat[7]), 1);
        ev_ovr = 1; ev_frm = 1; tick("R2");
        // R3: write 1 at bit 2 keeps errors
        wr_en = 1; wr_data = 8'h07; tick("R3");
        chk("R3", int'(rd_stat[7:5]), 3'b111);
        // R3: write 0 clears all three
        wr_en = 1; wr_data = 8'h03; tick("R3");
        chk("R3", int'(rd_stat[7:5]), 3'b000);
        chk("R8", int'(rx_data_valid), 1);
        // R4: set in the same cycle as clear
        ev_frm = 1; wr_en = 1; wr_data = 8'h03; tick("R4");
        chk("R4", int'(rd_stat[7:5]), 3'b001);
        ev_par = 1; ev_ovr = 1; wr_en = 1; wr_data = 8'h02; tick("R4");
        chk("R4", int'(rd_stat[7:5]), 3'b110);

        // random traffic, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            ev_par     = ($urandom_range(0, 15) == 0);
            ev_ovr     = ($urandom_range(0, 15) == 0);
            ev_frm     = ($urandom_range(0, 15) == 0);
            ev_rx_load = ($urandom_range(0, 3) == 0);
            data_rd    = ($urandom_range(0, 3) == 0);
            ev_tx_load = ($urandom_range(0, 3) == 0);
            ev_tx_take = ($urandom_range(0, 3) == 0);
            stat_rd    = ($urandom_range(0, 2) == 0);
            wr_en      = ($urandom_range(0, 5) == 0);
            wr_data    = 8'($urandom);
            tick("R2");
        end

        chk("R1", int'(model_byte() == rd_stat), 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule